// File: doc/BRIEF.md
# Integer Add, Reverse-Subtract and Compare Unit

This block is the arithmetic slice of a 32-bit integer execute stage. It covers the add, reverse-subtract and compare operations. From the decoded opcode and function fields it picks an operand source: a register, a sign-extended immediate, or an immediate whose upper half comes from a pending prefix. It then adds the first operand, or its inverse, to the second operand. The carry-in is either a constant or the stored carry flag. For a compare, the top bit of the difference is replaced by an ordering flag.

The result, the new carry value and the carry write enable are combinational in the issue cycle. The block also holds the architectural carry flag, which is updated at the next clock edge. A consume strobe tells the prefix holder to drop its pending upper half once an instruction has used it.

The reset is asynchronous and active low. Its release is synchronised inside the block over two clock edges.

Top module: `addsub_cmp_unit`

## Requirements
- R1: After reset the stored carry flag `carry_q` reads 0. With `op_valid` low, `result` reads 0.
- R2: The group holds opcodes whose two top bits (opcode[5:4]) are 00. Opcode 000000 gives `result` = B + A. `carry_nx` is the carry out of bit 31, and `carry_we` is 1.
- R3: When opcode[0] is 1, the operation is a reverse subtract, B + ~A + 1. A carry of 1 means no borrow, so B >= A unsigned.
- R4: When opcode[1] is 1, the stored carry flag replaces the constant carry-in. Add becomes B + A + C and reverse subtract becomes B + ~A + C.
- R5: When opcode[2] is 1, `carry_we` is 0 and the stored flag keeps its value.
- R6: When opcode[3] is 1 and no prefix is pending, the second operand is `imm16` sign-extended to 32 bits, in place of `opnd_b`.
- R7: When opcode[3] is 1 and `pfx_valid` is 1, the second operand is {`pfx_hi`, `imm16`}. `pfx_consume` is 1 for every valid in-group operation that arrives while `pfx_valid` is 1. A register-form operation consumes the prefix without using it.
- R8: Opcode 000101 with function 0x001 is a signed compare. `result`[30:0] equals (B - A)[30:0]. `result`[31] is 0 when B >= A as signed values and 1 otherwise.
- R9: Opcode 000101 with function 0x003 is the same compare with an unsigned ordering.
- R10: A compare never asserts `carry_we`.
- R11: On a clock edge with `carry_we` high, `carry_q` takes `carry_nx`. Otherwise `carry_q` holds its value.
- R12: Opcodes outside the group, or `op_valid` low, give `result` = 0, `res_valid` = 0, `carry_we` = 0 and `pfx_consume` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| opcode | input | 6 | Major opcode |
| func | input | 11 | Function field (selects compare) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, register form |
| imm16 | input | 16 | Instruction immediate |
| pfx_valid | input | 1 | A prefixed upper immediate half is pending |
| pfx_hi | input | 16 | Pending upper immediate half |
| result | output | 32 | Operation result |
| res_valid | output | 1 | Result belongs to a valid in-group operation |
| carry_nx | output | 1 | New carry value |
| carry_we | output | 1 | Carry flag update enable |
| carry_q | output | 1 | Stored carry flag |
| pfx_consume | output | 1 | Pending prefix has been used |

## Verification
In one cycle the unit can both read the stored carry flag as its carry-in and write a new carry value. Back-to-back carry-chained adds and subtracts expose any off-by-one between these two paths. The bench provokes this with directed carry chains and with random opcode streams. It checks each cycle's `carry_nx` against a model fed by the flag the bench itself has tracked from earlier operations. After every edge it compares `carry_q` with that tracked value.

A pending prefix can also meet an immediate-form, carry-chained operation. The result then depends on both the prefix and the carry, and it is judged against the same model.

// File: rtl/asc_pkg.sv
`timescale 1ns/1ps
package asc_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 11;
  localparam logic [FN_W-1:0] FN_CMP_S = 11'h001;
  localparam logic [FN_W-1:0] FN_CMP_U = 11'h003;
  localparam logic [OPC_W-1:0] OPC_CMP = 6'b000101;

  typedef struct packed {
    logic in_grp;
    logic rsub;
    logic use_c;
    logic keep;
    logic use_imm;
    logic is_cmp;
    logic cmp_uns;
  } asc_dec_t;
endpackage

// File: rtl/asc_decode.sv
`timescale 1ns/1ps
module asc_decode
  import asc_pkg::*;
(
  input  logic             op_valid,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  func,
  output asc_dec_t         dec
);
  logic grp;
  logic cmp_hit;

  always_comb begin
    grp     = op_valid && (opcode[OPC_W-1:OPC_W-2] == 2'b00);
    cmp_hit = (opcode == OPC_CMP) && ((func == FN_CMP_S) || (func == FN_CMP_U));
    dec.in_grp  = grp;
    dec.rsub    = opcode[0];
    dec.use_c   = opcode[1];
    dec.keep    = opcode[2];
    dec.use_imm = opcode[3];
    dec.is_cmp  = grp && cmp_hit;
    dec.cmp_uns = (func == FN_CMP_U);
  end
endmodule

// File: rtl/asc_operand.sv
`timescale 1ns/1ps
module asc_operand #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                    use_imm,
  input  logic                    pfx_valid,
  input  logic [DATA_W-IMM_W-1:0] pfx_hi,
  input  logic [IMM_W-1:0]        imm16,
  input  logic [DATA_W-1:0]       opnd_b,
  output logic [DATA_W-1:0]       b_sel
);
  localparam int PFX_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (PFX_W > 0) begin : g_ext
      always_comb begin
        if (pfx_valid) imm_ext = {pfx_hi, imm16};
        else           imm_ext = {{PFX_W{imm16[IMM_W-1]}}, imm16};
      end
    end else begin : g_full
      always_comb imm_ext = imm16[DATA_W-1:0];
    end
  endgenerate

  always_comb b_sel = use_imm ? imm_ext : opnd_b;
endmodule

// File: rtl/asc_addcmp.sv
`timescale 1ns/1ps
module asc_addcmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              rsub,
  input  logic              use_c,
  input  logic              carry_q,
  input  logic              is_cmp,
  input  logic              cmp_uns,
  output logic [DATA_W-1:0] sum_out,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] a_term;
  logic              cin;
  logic [DATA_W:0]   sum;
  logic              ovf;
  logic              lt_s;
  logic              lt_u;

  always_comb begin
    a_term = rsub ? ~a : a;
    cin    = use_c ? carry_q : rsub;
    sum    = {1'b0, b} + {1'b0, a_term} + {{DATA_W{1'b0}}, cin};
    cout   = sum[DATA_W];
    ovf    = (b[MSB] ^ a[MSB]) & (sum[MSB] ^ b[MSB]);
    lt_s   = sum[MSB] ^ ovf;
    lt_u   = ~sum[DATA_W];
    sum_out = sum[DATA_W-1:0];
    if (is_cmp) sum_out[MSB] = cmp_uns ? lt_u : lt_s;
  end
endmodule

// File: rtl/asc_carry_reg.sv
`timescale 1ns/1ps
module asc_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q
);
  logic q_nx;

  always_comb begin
    q_nx = q;
    if (we) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nx;
  end
endmodule

// File: rtl/addsub_cmp_unit.sv
`timescale 1ns/1ps
module addsub_cmp_unit
  import asc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [OPC_W-1:0]        opcode,
  input  logic [FN_W-1:0]         func,
  input  logic [DATA_W-1:0]       opnd_a,
  input  logic [DATA_W-1:0]       opnd_b,
  input  logic [IMM_W-1:0]        imm16,
  input  logic                    pfx_valid,
  input  logic [DATA_W-IMM_W-1:0] pfx_hi,
  output logic [DATA_W-1:0]       result,
  output logic                    res_valid,
  output logic                    carry_nx,
  output logic                    carry_we,
  output logic                    carry_q,
  output logic                    pfx_consume
);
  localparam int MSB = DATA_W - 1;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  asc_dec_t          dec;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] raw_sum;
  logic              raw_cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  asc_decode u_dec (
    .op_valid (op_valid),
    .opcode   (opcode),
    .func     (func),
    .dec      (dec)
  );

  asc_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .use_imm   (dec.use_imm),
    .pfx_valid (pfx_valid),
    .pfx_hi    (pfx_hi),
    .imm16     (imm16),
    .opnd_b    (opnd_b),
    .b_sel     (b_sel)
  );

  asc_addcmp #(.DATA_W(DATA_W)) u_core (
    .a       (opnd_a),
    .b       (b_sel),
    .rsub    (dec.rsub),
    .use_c   (dec.use_c),
    .carry_q (carry_q),
    .is_cmp  (dec.is_cmp),
    .cmp_uns (dec.cmp_uns),
    .sum_out (raw_sum),
    .cout    (raw_cout)
  );

  always_comb begin
    res_valid   = dec.in_grp;
    result      = dec.in_grp ? raw_sum : '0;
    carry_nx    = raw_cout;
    carry_we    = dec.in_grp && !dec.keep && !dec.is_cmp;
    pfx_consume = dec.in_grp && pfx_valid;
  end

  asc_carry_reg u_cflag (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (carry_we),
    .d     (carry_nx),
    .q     (carry_q)
  );

  logic [DATA_W-1:0] chk_diff;
  assign chk_diff = opnd_b - opnd_a;

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(op_valid && opcode[OPC_W-1:OPC_W-2] == 2'b00) |-> (!carry_we && !pfx_consume && result == '0));
  assert_keep_no_write_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && opcode[2]) |-> !carry_we);
  assert_cmp_no_write_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && opcode == OPC_CMP && (func == FN_CMP_S || func == FN_CMP_U)) |-> !carry_we);
  assert_cmp_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && opcode == OPC_CMP && (func == FN_CMP_S || func == FN_CMP_U))
      |-> result[MSB-1:0] == chk_diff[MSB-1:0]);
  assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !carry_we |=> $stable(carry_q));
  assert_flag_load_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    carry_we |=> carry_q == $past(carry_nx));
  assert_consume_needs_pfx_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pfx_consume |-> (op_valid && pfx_valid && res_valid));
endmodule

// File: tb/addsub_cmp_unit_test.sv
`timescale 1ns/1ps
module addsub_cmp_unit_test;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [5:0]  opcode;
  logic [10:0] func;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [15:0] imm16;
  logic        pfx_valid;
  logic [15:0] pfx_hi;
  logic [31:0] result;
  logic        res_valid;
  logic        carry_nx;
  logic        carry_we;
  logic        carry_q;
  logic        pfx_consume;

  int checks = 0;
  int errors = 0;
  logic mdl_c = 1'b0;

  addsub_cmp_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .func(func),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .pfx_valid(pfx_valid),
    .pfx_hi(pfx_hi), .result(result), .res_valid(res_valid), .carry_nx(carry_nx),
    .carry_we(carry_we), .carry_q(carry_q), .pfx_consume(pfx_consume)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic void model(input logic v, input logic [5:0] opc, input logic [10:0] fn,
                                input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                                input logic pv, input logic [15:0] ph, input logic c,
                                output logic [31:0] res, output logic cy, output logic we,
                                output logic rv, output logic cons);
    logic grp, cmp, cin;
    logic [31:0] bop, aop;
    logic [32:0] s;
    grp = v && (opc[5:4] == 2'b00);
    cmp = (opc == 6'b000101) && (fn == 11'h001 || fn == 11'h003);
    bop = opc[3] ? (pv ? {ph, imm} : {{16{imm[15]}}, imm}) : b;
    aop = opc[0] ? ~a : a;
    cin = opc[1] ? c : opc[0];
    s = {1'b0, bop} + {1'b0, aop} + {32'd0, cin};
    res = s[31:0];
    if (cmp) res[31] = (fn == 11'h001) ? ($signed(b) < $signed(a)) : (b < a);
    cy = s[32];
    we = grp && !opc[2] && !cmp;
    rv = grp;
    cons = grp && pv;
    if (!grp) res = 32'd0;
  endfunction

  task automatic do_op(input logic v, input logic [5:0] opc, input logic [10:0] fn,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                       input logic pv, input logic [15:0] ph);
    logic [31:0] e_res;
    logic e_cy, e_we, e_rv, e_cons, cmp;
    string rtag, wtag;
    @(negedge clk);
    op_valid = v; opcode = opc; func = fn; opnd_a = a; opnd_b = b;
    imm16 = imm; pfx_valid = pv; pfx_hi = ph;
    #2;
    model(v, opc, fn, a, b, imm, pv, ph, mdl_c, e_res, e_cy, e_we, e_rv, e_cons);
    cmp = (opc == 6'b000101) && (fn == 11'h001 || fn == 11'h003);
    if (!v || opc[5:4] != 2'b00) rtag = "R12";
    else if (cmp)                rtag = (fn == 11'h001) ? "R8" : "R9";
    else if (opc[3])             rtag = pv ? "R7" : "R6";
    else if (opc[1])             rtag = "R4";
    else if (opc[0])             rtag = "R3";
    else                         rtag = "R2";
    if (!e_rv)       wtag = "R12";
    else if (cmp)    wtag = "R10";
    else if (opc[2]) wtag = "R5";
    else             wtag = "R2";
    chk(rtag, "result", result, e_res);
    chk(rtag, "res_valid", {31'd0, res_valid}, {31'd0, e_rv});
    chk(wtag, "carry_we", {31'd0, carry_we}, {31'd0, e_we});
    if (e_we) chk(rtag, "carry_nx", {31'd0, carry_nx}, {31'd0, e_cy});
    chk("R7", "pfx_consume", {31'd0, pfx_consume}, {31'd0, e_cons});
    @(posedge clk);
    if (e_we) mdl_c = e_cy;
    #1;
    chk(opc[2] ? "R5" : "R11", "carry_q", {31'd0, carry_q}, {31'd0, mdl_c});
  endtask

  function automatic logic [31:0] pick();
    logic [2:0] k;
    k = 3'($urandom_range(0, 9));
    case (k)
      3'd0: return 32'h0000_0000;
      3'd1: return 32'h0000_0001;
      3'd2: return 32'h7FFF_FFFF;
      3'd3: return 32'h8000_0000;
      3'd4: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0; func = '0; opnd_a = '0;
    opnd_b = '0; imm16 = '0; pfx_valid = 1'b0; pfx_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "carry_q after reset", {31'd0, carry_q}, 32'd0);
    chk("R1", "idle result", result, 32'd0);

    // R2: add wrapping with carry out
    do_op(1, 6'b000000, 0, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0);
    // R4: carry-chained add uses the flag just written
    do_op(1, 6'b000010, 0, 32'h0000_0005, 32'h0000_0007, 0, 0, 0);
    // R3: equal operands, no borrow
    do_op(1, 6'b000001, 0, 32'h1234_5678, 32'h1234_5678, 0, 0, 0);
    // R3: borrow
    do_op(1, 6'b000001, 0, 32'h0000_0009, 32'h0000_0002, 0, 0, 0);
    // R4: reverse subtract with carry-in clear
    do_op(1, 6'b000011, 0, 32'h0000_0001, 32'h0000_0003, 0, 0, 0);
    // R5: keep forms leave the flag alone
    do_op(1, 6'b000100, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
    do_op(1, 6'b000110, 0, 32'h0000_0001, 32'h0000_0001, 0, 0, 0);
    // R6: negative immediate
    do_op(1, 6'b001000, 0, 32'h0000_0010, 32'hDEAD_BEEF, 16'hFFF0, 0, 16'hABCD);
    // R7: prefixed immediate with carry-in
    do_op(1, 6'b001010, 0, 32'h0000_0001, 32'h0, 16'h8000, 1, 16'h1234);
    // R7: register form consumes the prefix but ignores it
    do_op(1, 6'b000000, 0, 32'h0000_0002, 32'h0000_0003, 16'h5555, 1, 16'h7777);
    // R8 / R9: signed and unsigned ordering diverge
    do_op(1, 6'b000101, 11'h001, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0);
    do_op(1, 6'b000101, 11'h003, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0);
    do_op(1, 6'b000101, 11'h001, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0);
    do_op(1, 6'b000101, 11'h003, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0);
    do_op(1, 6'b000101, 11'h001, 32'h0000_0004, 32'h0000_0004, 0, 0, 0);
    // R12: out-of-group opcode and idle slot
    do_op(1, 6'b100000, 0, 32'h1, 32'h2, 0, 1, 16'h1);
    do_op(0, 6'b000000, 0, 32'h1, 32'h2, 0, 1, 16'h1);

    for (int i = 0; i < 600; i++) begin
      logic [5:0]  o;
      logic [10:0] f;
      o = ($urandom_range(0, 15) == 0) ? 6'($urandom) : {2'b00, 4'($urandom)};
      f = 11'd0;
      if (o == 6'b000101) begin
        case ($urandom_range(0, 2))
          0: f = 11'h000;
          1: f = 11'h001;
          default: f = 11'h003;
        endcase
      end
      do_op($urandom_range(0, 15) != 0, o, f, pick(), pick(), 16'($urandom),
            $urandom_range(0, 3) == 0, 16'($urandom));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule